// File: doc/BRIEF.md
# Multi-Mode Load Address Unit

This block carries out load operations for a small register-based processor core. A request names one of several operand addressing modes, a destination register, a base register, an index register and a 16-bit signed offset. The unit reads its own general-purpose register file and forms the effective address. It issues one or two reads to a synchronous word memory that has a fixed one-cycle read latency. It writes the returned word into the destination register. In the auto-modify modes it also writes the stepped value back into the base register.

A request is taken on `req_valid` while the unit is idle. `busy` then stays high until a single-cycle `done` pulse ends the operation. The memory-indirect mode chains two reads: the first word fetched becomes the address of the second. A reserved mode code ends the operation at once with `illegal` raised. A third register read port, `rf_rsel`/`rf_rdata`, lets the rest of the core read operands out of the same register file.

Top module: `ldaddr_unit`

## Requirements
- R1: Mode code 0 (absolute): the load address is the 16-bit offset field, sign-extended to 32 bits.
- R2: Mode code 1 (register indirect): the load address is the contents of the base register.
- R3: Mode code 2 (displaced): the load address is the base register contents plus the sign-extended offset.
- R4: Mode code 3 (indexed): the load address is the sum of the base register and index register contents.
- R5: Mode code 4 (memory indirect): the unit makes exactly two reads. The first goes to the base register contents, and the word it returns is the address of the second. The second word is loaded.
- R6: Mode code 5 (post-increment): the unit reads at the base register contents, then the base register holds its old value plus 4.
- R7: Mode code 6 (pre-decrement): the base register minus 4 is both the load address and the new base register value.
- R8: In modes 5 and 6, when the destination and base registers are the same, that register ends with the loaded word.
- R9: Mode code 7 is reserved. It raises `illegal` together with `done`, makes no memory read and leaves every register unchanged.
- R10: Register 0 always reads zero. Loads or base updates aimed at it have no effect.
- R11: A request accepted at clock edge k gives a one-cycle `done` in the cycle after edge k+2 for single-read modes, after edge k+3 for memory indirect and after edge k for the reserved mode. `busy` is high from acceptance through the `done` cycle and low after it.
- R12: After reset `busy`, `done`, `illegal` and `mem_rd` are low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Load request present; taken when not busy |
| req_mode | input | 3 | Addressing mode code (0..7) |
| req_dst | input | 4 | Destination register index |
| req_base | input | 4 | Base register index |
| req_idx | input | 4 | Index register index |
| req_imm | input | 16 | Signed offset / absolute address field |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Reserved mode, valid with done |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Memory byte address |
| mem_rdata | input | 32 | Read data, valid the cycle after mem_rd |
| rf_rsel | input | 4 | Register select for the operand read port |
| rf_rdata | output | 32 | Contents of the selected register |

## Verification
The bench aims at the cases where address arithmetic and register write-back interact. A negative displacement catches an offset that is zero-extended instead of sign-extended. A memory-indirect load catches a design that loads the pointer word itself, or that fetches from the base address twice. Auto-modify loads whose destination is also the base catch write-port priority that lets the stepped base overwrite the loaded word. A pre-decrement catches a design that reads before stepping. The reserved code, a load into register 0 and an auto-increment of register 0 check for memory traffic or register changes that must not happen.

// File: rtl/ldaddr_pkg.sv
package ldaddr_pkg;

   typedef enum logic [2:0] {
      M_ABS  = 3'd0,
      M_RIND = 3'd1,
      M_DISP = 3'd2,
      M_IDX  = 3'd3,
      M_MIND = 3'd4,
      M_AINC = 3'd5,
      M_ADEC = 3'd6,
      M_RSVD = 3'd7
   } lmode_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_ISSUE,
      ST_PTR,
      ST_DATA,
      ST_FIN
   } lstate_e;

endpackage

// File: rtl/ldaddr_regfile.sv
module ldaddr_regfile #(
   parameter int DATA_W = 32,
   parameter int NREGS  = 16,
   localparam int RIDX_W = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [RIDX_W-1:0] ra,
   input  logic [RIDX_W-1:0] rb,
   input  logic [RIDX_W-1:0] rc,
   output logic [DATA_W-1:0] rd_a,
   output logic [DATA_W-1:0] rd_b,
   output logic [DATA_W-1:0] rd_c,
   input  logic              we_d,
   input  logic [RIDX_W-1:0] wd_idx,
   input  logic [DATA_W-1:0] wd,
   input  logic              we_b,
   input  logic [RIDX_W-1:0] wb_idx,
   input  logic [DATA_W-1:0] wb
);

   logic [DATA_W-1:0] regs [NREGS];

   for (genvar g = 0; g < NREGS; g++) begin : g_reg
      if (g == 0) begin : g_zero
         assign regs[g] = '0;
      end else begin : g_flop
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (we_d && wd_idx == RIDX_W'(g))
               q <= wd;
            else if (we_b && wb_idx == RIDX_W'(g))
               q <= wb;
         end
         assign regs[g] = q;
      end
   end

   assign rd_a = regs[ra];
   assign rd_b = regs[rb];
   assign rd_c = regs[rc];

   AST_DST_BEATS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      (we_d && we_b && wd_idx == wb_idx && wd_idx != '0) |=> (regs[$past(wd_idx)] == $past(wd))); // R8

   AST_R0_STAYS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (we_d && wd_idx == '0) |=> (rd_c == '0 || rc != '0)); // R10

endmodule

// File: rtl/ldaddr_agen.sv
module ldaddr_agen
   import ldaddr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int OFFS_W     = 16,
   parameter int WORD_BYTES = 4
) (
   input  lmode_e            mode,
   input  logic [DATA_W-1:0] base_v,
   input  logic [DATA_W-1:0] idx_v,
   input  logic [OFFS_W-1:0] offs,
   output logic [DATA_W-1:0] ea,
   output logic [DATA_W-1:0] base_upd,
   output logic              upd_en
);

   localparam logic [DATA_W-1:0] STEP = DATA_W'(WORD_BYTES);

   logic [DATA_W-1:0] offs_sx;
   assign offs_sx = {{(DATA_W-OFFS_W){offs[OFFS_W-1]}}, offs};

   always_comb begin
      ea       = '0;
      base_upd = base_v;
      upd_en   = 1'b0;
      unique case (mode)
         M_ABS:  ea = offs_sx;
         M_RIND: ea = base_v;
         M_DISP: ea = base_v + offs_sx;
         M_IDX:  ea = base_v + idx_v;
         M_MIND: ea = base_v;
         M_AINC: begin
            ea       = base_v;
            base_upd = base_v + STEP;
            upd_en   = 1'b1;
         end
         M_ADEC: begin
            base_upd = base_v - STEP;
            ea       = base_upd;
            upd_en   = 1'b1;
         end
         default: ea = '0;
      endcase
   end

endmodule

// File: rtl/ldaddr_unit.sv
module ldaddr_unit
   import ldaddr_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int NREGS      = 16,
   parameter int OFFS_W     = 16,
   parameter int WORD_BYTES = 4,
   localparam int RIDX_W    = $clog2(NREGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [2:0]        req_mode,
   input  logic [RIDX_W-1:0] req_dst,
   input  logic [RIDX_W-1:0] req_base,
   input  logic [RIDX_W-1:0] req_idx,
   input  logic [OFFS_W-1:0] req_imm,
   output logic              busy,
   output logic              done,
   output logic              illegal,
   output logic              mem_rd,
   output logic [DATA_W-1:0] mem_addr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [RIDX_W-1:0] rf_rsel,
   output logic [DATA_W-1:0] rf_rdata
);

   if (OFFS_W > DATA_W) begin : g_chk_offs
      $error("ldaddr_unit: OFFS_W must not exceed DATA_W");
   end
   if (NREGS < 2 || (1 << RIDX_W) != NREGS) begin : g_chk_regs
      $error("ldaddr_unit: NREGS must be a power of two >= 2");
   end
   if (WORD_BYTES < 1) begin : g_chk_step
      $error("ldaddr_unit: WORD_BYTES must be positive");
   end

   lstate_e           state_q;
   lmode_e            mode_q;
   logic [RIDX_W-1:0] dst_q, base_q, idx_q;
   logic [OFFS_W-1:0] imm_q;
   logic              ill_q;
   logic [1:0]        rdcnt_q;

   logic              accept;
   logic [DATA_W-1:0] base_v, idx_v, ea, base_upd;
   logic              upd_en;

   assign accept = (state_q == ST_IDLE) && req_valid;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= M_ABS;
         dst_q   <= '0;
         base_q  <= '0;
         idx_q   <= '0;
         imm_q   <= '0;
         ill_q   <= 1'b0;
      end else begin
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               mode_q  <= lmode_e'(req_mode);
               dst_q   <= req_dst;
               base_q  <= req_base;
               idx_q   <= req_idx;
               imm_q   <= req_imm;
               ill_q   <= (lmode_e'(req_mode) == M_RSVD);
               state_q <= (lmode_e'(req_mode) == M_RSVD) ? ST_FIN : ST_ISSUE;
            end
            ST_ISSUE: state_q <= (mode_q == M_MIND) ? ST_PTR : ST_DATA;
            ST_PTR:   state_q <= ST_DATA;
            ST_DATA:  state_q <= ST_FIN;
            ST_FIN:   state_q <= ST_IDLE;
            default:  state_q <= ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rdcnt_q <= '0;
      else if (accept)
         rdcnt_q <= '0;
      else if (mem_rd)
         rdcnt_q <= rdcnt_q + 2'd1;
   end

   ldaddr_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
      .clk    (clk),
      .rst_n  (rst_n),
      .ra     (base_q),
      .rb     (idx_q),
      .rc     (rf_rsel),
      .rd_a   (base_v),
      .rd_b   (idx_v),
      .rd_c   (rf_rdata),
      .we_d   (state_q == ST_DATA),
      .wd_idx (dst_q),
      .wd     (mem_rdata),
      .we_b   ((state_q == ST_DATA) && upd_en),
      .wb_idx (base_q),
      .wb     (base_upd)
   );

   ldaddr_agen #(.DATA_W(DATA_W), .OFFS_W(OFFS_W), .WORD_BYTES(WORD_BYTES)) u_agen (
      .mode     (mode_q),
      .base_v   (base_v),
      .idx_v    (idx_v),
      .offs     (imm_q),
      .ea       (ea),
      .base_upd (base_upd),
      .upd_en   (upd_en)
   );

   assign busy     = (state_q != ST_IDLE);
   assign done     = (state_q == ST_FIN);
   assign illegal  = done && ill_q;
   assign mem_rd   = (state_q == ST_ISSUE) || (state_q == ST_PTR);
   assign mem_addr = (state_q == ST_PTR) ? mem_rdata : ea;

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R11

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R11

   AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> busy); // R11

   AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      illegal |-> (rdcnt_q == 2'd0 && !mem_rd)); // R9

   AST_READ_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !illegal) |-> (rdcnt_q == ((mode_q == M_MIND) ? 2'd2 : 2'd1))); // R5

endmodule

// File: tb/ldaddr_unit_tb.sv
module ldaddr_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [2:0]  req_mode = '0;
   logic [3:0]  req_dst = '0, req_base = '0, req_idx = '0;
   logic [15:0] req_imm = '0;
   logic        busy, done, illegal, mem_rd;
   logic [31:0] mem_addr;
   logic [31:0] mem_rdata = '0;
   logic [3:0]  rf_rsel = '0;
   logic [31:0] rf_rdata;

   int nchk = 0;
   int nfail = 0;

   logic [31:0] mem  [256];
   logic [31:0] rref [16];

   always #5 clk = ~clk;

   always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];

   ldaddr_unit u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mode(req_mode),
      .req_dst(req_dst), .req_base(req_base), .req_idx(req_idx), .req_imm(req_imm),
      .busy(busy), .done(done), .illegal(illegal), .mem_rd(mem_rd),
      .mem_addr(mem_addr), .mem_rdata(mem_rdata), .rf_rsel(rf_rsel), .rf_rdata(rf_rdata)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic chk_regs(input string req);
      for (int r = 0; r < 16; r++) begin
         @(negedge clk);
         rf_rsel = 4'(r);
         #1;
         chk(rf_rdata === rref[r], req, $sformatf("reg %0d", r), rf_rdata, rref[r]);
      end
   endtask

   task automatic run_load(input logic [2:0] m, input logic [3:0] d, input logic [3:0] b,
                           input logic [3:0] x, input logic [15:0] imm, input string req);
      logic [31:0] bv, xv, se, ea, fin, data, nb;
      logic [31:0] seen [4];
      int exp_lat, exp_rd, nrd, cyc;
      bit upd;
      bv = rref[b]; xv = rref[x]; se = {{16{imm[15]}}, imm};
      upd = 1'b0; nb = bv; exp_lat = 2; exp_rd = 1;
      case (m)
         3'd0: ea = se;
         3'd1: ea = bv;
         3'd2: ea = bv + se;
         3'd3: ea = bv + xv;
         3'd4: begin ea = bv; exp_lat = 3; exp_rd = 2; end
         3'd5: begin ea = bv; nb = bv + 32'd4; upd = 1'b1; end
         3'd6: begin ea = bv - 32'd4; nb = ea; upd = 1'b1; end
         default: begin ea = 32'd0; exp_lat = 0; exp_rd = 0; end
      endcase
      fin  = (m == 3'd4) ? mem[ea[9:2]] : ea;
      data = mem[fin[9:2]];
      @(negedge clk);
      req_valid = 1'b1; req_mode = m; req_dst = d; req_base = b; req_idx = x; req_imm = imm;
      @(negedge clk);
      req_valid = 1'b0;
      nrd = 0; cyc = 0;
      while (1) begin
         if (mem_rd && nrd < 4) seen[nrd] = mem_addr;
         if (mem_rd) nrd++;
         if (!busy) begin
            chk(0, "R11", "busy low during operation", 32'(busy), 32'd1);
            break;
         end
         if (done || cyc > 8) break;
         @(negedge clk);
         cyc++;
      end
      chk(cyc == exp_lat, "R11", "done latency", 32'(cyc), 32'(exp_lat));
      chk(nrd == exp_rd, req, "memory read count", 32'(nrd), 32'(exp_rd));
      chk(illegal === (m == 3'd7), req, "illegal flag", 32'(illegal), 32'(m == 3'd7));
      if (exp_rd >= 1 && nrd >= 1) chk(seen[0] === ea, req, "first read address", seen[0], ea);
      if (exp_rd == 2 && nrd >= 2) chk(seen[1] === fin, req, "pointer read address", seen[1], fin);
      @(negedge clk);
      chk(!busy && !done, "R11", "idle after done", {busy, done}, 32'd0);
      if (m != 3'd7) begin
         if (upd && b != 4'd0) rref[b] = nb;
         if (d != 4'd0) rref[d] = data;
      end
      chk_regs(req);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      nchk++; nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

   initial begin
      for (int i = 0; i < 256; i++)
         mem[i] = (i < 32) ? (32'(i) * 32'd4 + 32'd64) : (32'hA000_0000 + 32'(i));
      for (int i = 0; i < 16; i++) rref[i] = 32'd0;
      repeat (3) @(negedge clk);
      #1;
      chk({busy, done, illegal, mem_rd} === 4'b0, "R12", "outputs after reset",
          32'({busy, done, illegal, mem_rd}), 32'd0);
      rst_n = 1'b1;
      chk_regs("R12");

      run_load(3'd0, 4'd1, 4'd0, 4'd0, 16'h0008, "R1");   // r1 = 72
      run_load(3'd0, 4'd2, 4'd0, 4'd0, 16'h0010, "R1");   // r2 = 80
      run_load(3'd0, 4'd3, 4'd0, 4'd0, 16'h0004, "R1");   // r3 = 68
      run_load(3'd1, 4'd4, 4'd1, 4'd0, 16'h0000, "R2");
      run_load(3'd2, 4'd5, 4'd2, 4'd0, 16'hFFF8, "R3");   // negative offset
      run_load(3'd2, 4'd11, 4'd2, 4'd0, 16'h0020, "R3");
      run_load(3'd3, 4'd6, 4'd3, 4'd1, 16'h0000, "R4");
      run_load(3'd4, 4'd7, 4'd3, 4'd0, 16'h0000, "R5");
      run_load(3'd5, 4'd8, 4'd2, 4'd0, 16'h0000, "R6");
      run_load(3'd6, 4'd9, 4'd3, 4'd0, 16'h0000, "R7");
      run_load(3'd5, 4'd2, 4'd2, 4'd0, 16'h0000, "R8");
      run_load(3'd6, 4'd3, 4'd3, 4'd0, 16'h0000, "R8");
      run_load(3'd7, 4'd10, 4'd1, 4'd0, 16'h0004, "R9");
      run_load(3'd0, 4'd0, 4'd0, 4'd0, 16'h0040, "R10");
      run_load(3'd5, 4'd12, 4'd0, 4'd0, 16'h0000, "R10");
      run_load(3'd4, 4'd13, 4'd0, 4'd0, 16'h0000, "R5");

      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
   end

endmodule